// File: doc/BRIEF.md
# Transmit Power Ramp Sequencer

This block orders the power-up and power-down of a radio transmitter so that the output spectrum does not splatter. A transmission can begin only while the radio sits idle with its synthesizer locked. Two sources can start it: a rising edge on an external trigger pin, or a start command written to the command port. Once a transmission is accepted, the block reports busy-transmit. It raises the data-start strobe exactly one symbol period later.

Before data start, the power amplifier is switched on at gain code zero. The lead time is programmable, and the gain then climbs one code per step interval up to the configured code. The lead time actually used is stretched when the climb would not otherwise finish by the data-start strobe. When the modulator signals that the frame has gone out, the gain walks back down to zero and the amplifier is switched off one step later. The block then returns to idle and emits a one-cycle completion pulse.

Top module: `tx_ramp_seq`

## Requirements
- R1: While the state is idle and `pll_locked` is 1, either of two events accepts a transmission: a 0-to-1 change of `trig_pin` between two consecutive clock samples, or `cmd_wr` = 1 with `cmd_code` = 5'h02. `busy_tx` is 1 from the next cycle on. The pin's history register resets to 1, so a pin that is held high through reset starts nothing.
- R2: A start request is ignored, with no effect on any output, when the block is not idle or when `pll_locked` is 0. A `cmd_code` other than 5'h02 is ignored as well.
- R3: `data_start` is a one-cycle pulse in the cycle that begins exactly SYM_CYC clock edges after the accepting edge.
- R4: `pa_en` rises SYM_CYC − L edges after the accepting edge. L is the larger of (`lead_sel`+1)·LEAD_UNIT and `gain_cfg`·STEP_CYC, capped at SYM_CYC. `lead_sel` and `gain_cfg` are captured at acceptance.
- R5: When `pa_en` rises, `pa_gain` is 0. It then increases by exactly 1 every STEP_CYC cycles until it equals the captured gain, which it holds by the time `data_start` is high.
- R6: A `tx_done` = 1 in the transmitting phase starts the ramp-down. `pa_gain` falls by 1 every STEP_CYC cycles. One further STEP_CYC after reaching 0, `pa_en` drops. `pa_gain` is 0 whenever `pa_en` is 0.
- R7: In the cycle `pa_en` drops, `busy_tx` drops and `ramp_done` is high for exactly one cycle. `tx_done` outside the transmitting phase has no effect.
- R8: A trigger edge and a start command in the same cycle start a single transmission, with a single `data_start` and a single `ramp_done`.
- R9: After reset, `pa_en`, `pa_gain`, `data_start`, `busy_tx` and `ramp_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_locked | input | 1 | Synthesizer locked; qualifies starts |
| trig_pin | input | 1 | External start trigger, rising edge |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 5 | Command value; 5'h02 requests a start |
| lead_sel | input | 2 | Amplifier lead time in LEAD_UNIT multiples (value+1) |
| gain_cfg | input | GAIN_W | Target amplifier gain code |
| tx_done | input | 1 | Frame sent; begins ramp-down |
| pa_en | output | 1 | Power amplifier enable |
| pa_gain | output | GAIN_W | Power amplifier gain code |
| data_start | output | 1 | One-cycle strobe that begins data |
| busy_tx | output | 1 | Transmission sequence in progress |
| ramp_done | output | 1 | One-cycle pulse when back to idle |

## Verification
The two start sources can fire in the same cycle. The bench raises `trig_pin` on the same falling edge that `cmd_wr` is driven with the start code, in one third of its runs. It judges the outcome by a single `data_start` at the expected cycle and a single `ramp_done`, with `busy_tx` staying low afterwards. A second collision lies between a start request or `tx_done` and a sequence that is already running. Every run injects such pulses during the lead phase and expects the per-cycle waveform of all outputs to be unchanged. The gain and lead settings are swept over every combination.

// File: rtl/tx_ramp_pkg.sv
// Shared definitions for the transmit power ramp sequencer.
package tx_ramp_pkg;
    localparam int CMD_W = 5;
    localparam logic [CMD_W-1:0] CMD_TX_GO = 5'h02;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_SEND = 2'd2,
        SQ_FALL = 2'd3
    } seq_state_t;
endpackage

// File: rtl/tx_ramp_start.sv
// Start request qualifier. Detects a rising edge on the trigger pin and a
// start command, and accepts either only while ready_i is high.
// Assumes trig_pin is already synchronous to clk.
module tx_ramp_start
    import tx_ramp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready_i,
    input  logic             trig_pin,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             start_o
);
    logic trig_q;
    logic trig_rise;
    logic cmd_hit;

    // Pin history; resets high so a pin held high across reset is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b1;
        else        trig_q <= trig_pin;
    end

    // Merge both sources; same-cycle requests yield one start.
    always_comb begin
        trig_rise = trig_pin & ~trig_q;
        cmd_hit   = cmd_wr & (cmd_code == CMD_TX_GO);
        start_o   = ready_i & (trig_rise | cmd_hit);
    end
endmodule

// File: rtl/tx_ramp_gain.sv
// Gain stepper. Moves the gain code one step per STEP_CYC cycles, up towards
// target while up_en is high, or down while dn_en is high. floor_tick
// marks a step interval that ends with the gain already at zero.
// Assumes up_en and dn_en are never high together.
module tx_ramp_gain #(
    parameter int GAIN_W   = 4,
    parameter int STEP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_en,
    input  logic              dn_en,
    input  logic [GAIN_W-1:0] target,
    output logic [GAIN_W-1:0] gain,
    output logic              floor_tick
);
    localparam int SC_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

    logic [SC_W-1:0] sc;
    logic            tick;
    logic            up_go;
    logic            moving;

    // Step interval decode and movement qualifiers.
    always_comb begin
        tick       = (sc == SC_W'(STEP_CYC - 1));
        up_go      = up_en & (gain < target);
        moving     = up_go | dn_en;
        floor_tick = dn_en & tick & (gain == '0);
    end

    // Step counter and gain register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc   <= '0;
            gain <= '0;
        end else if (moving) begin
            if (tick) begin
                sc <= '0;
                if (up_go)              gain <= gain + GAIN_W'(1);
                else if (gain != '0)    gain <= gain - GAIN_W'(1);
            end else begin
                sc <= sc + SC_W'(1);
            end
        end else begin
            sc <= '0;
        end
    end

    p_gain_le_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= target);

    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gain == $past(gain)) || (gain == $past(gain) + GAIN_W'(1)) ||
        (gain == $past(gain) - GAIN_W'(1)));
endmodule

// File: rtl/tx_ramp_ctrl.sv
// Sequencing state machine. Counts the symbol period from acceptance, turns
// the amplifier on at the effective lead time, strobes data start, and
// waits for tx_done before ramping down and returning to idle.
// Assumes (2**GAIN_W-1)*STEP_CYC <= SYM_CYC and 4*LEAD_UNIT <= SYM_CYC.
module tx_ramp_ctrl
    import tx_ramp_pkg::*;
#(
    parameter int SYM_CYC   = 32,
    parameter int LEAD_UNIT = 4,
    parameter int STEP_CYC  = 2,
    parameter int GAIN_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_locked,
    input  logic              start_i,
    input  logic [1:0]        lead_sel,
    input  logic [GAIN_W-1:0] gain_cfg,
    input  logic              tx_done,
    input  logic              floor_tick,
    output logic              ready_o,
    output logic              up_en,
    output logic              dn_en,
    output logic [GAIN_W-1:0] target_q,
    output logic              pa_en,
    output logic              data_start,
    output logic              busy_tx,
    output logic              ramp_done
);
    localparam int CNT_W = $clog2(SYM_CYC + 1);
    localparam int LW    = CNT_W + GAIN_W + 4;

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] on_at_q;
    logic [CNT_W-1:0] on_at_d;
    logic [LW-1:0]    lead_base;
    logic [LW-1:0]    ramp_need;
    logic [LW-1:0]    lead_eff;

    // Effective lead: the larger of programmed lead and ramp time, capped.
    always_comb begin
        lead_base = (LW'(lead_sel) + LW'(1)) * LW'(LEAD_UNIT);
        ramp_need = LW'(gain_cfg) * LW'(STEP_CYC);
        lead_eff  = (ramp_need > lead_base) ? ramp_need : lead_base;
        if (lead_eff > LW'(SYM_CYC)) lead_eff = LW'(SYM_CYC);
        on_at_d   = CNT_W'(LW'(SYM_CYC) - lead_eff);
    end

    // State decodes shared with the start qualifier and gain stepper.
    always_comb begin
        ready_o = (state == SQ_IDLE) & pll_locked;
        busy_tx = (state != SQ_IDLE);
        up_en   = pa_en & ((state == SQ_LEAD) | (state == SQ_SEND));
        dn_en   = (state == SQ_FALL);
    end

    // Sequence state, symbol counter and amplifier enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            cnt        <= '0;
            on_at_q    <= '0;
            target_q   <= '0;
            pa_en      <= 1'b0;
            data_start <= 1'b0;
            ramp_done  <= 1'b0;
        end else begin
            data_start <= 1'b0;
            ramp_done  <= 1'b0;
            unique case (state)
                SQ_IDLE: if (start_i) begin
                    state    <= SQ_LEAD;
                    cnt      <= '0;
                    on_at_q  <= on_at_d;
                    target_q <= gain_cfg;
                    pa_en    <= (on_at_d == '0);
                end
                SQ_LEAD: begin
                    cnt <= cnt + CNT_W'(1);
                    if (cnt + CNT_W'(1) == on_at_q) pa_en <= 1'b1;
                    if (cnt == CNT_W'(SYM_CYC - 1)) begin
                        state      <= SQ_SEND;
                        data_start <= 1'b1;
                    end
                end
                SQ_SEND: if (tx_done) state <= SQ_FALL;
                SQ_FALL: if (floor_tick) begin
                    state     <= SQ_IDLE;
                    pa_en     <= 1'b0;
                    ramp_done <= 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    p_data_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |=> !data_start);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |=> !ramp_done && !busy_tx);

    p_pa_before_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |-> pa_en);
endmodule

// File: rtl/tx_ramp_seq.sv
// Transmit power ramp sequencer top. Ties together the start qualifier, the
// sequencing state machine and the gain stepper.
// Assumes all inputs are synchronous to clk.
module tx_ramp_seq
    import tx_ramp_pkg::*;
#(
    parameter int SYM_CYC   = 32,
    parameter int LEAD_UNIT = 4,
    parameter int STEP_CYC  = 2,
    parameter int GAIN_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_locked,
    input  logic              trig_pin,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [1:0]        lead_sel,
    input  logic [GAIN_W-1:0] gain_cfg,
    input  logic              tx_done,
    output logic              pa_en,
    output logic [GAIN_W-1:0] pa_gain,
    output logic              data_start,
    output logic              busy_tx,
    output logic              ramp_done
);
    logic              ready;
    logic              start;
    logic              up_en;
    logic              dn_en;
    logic              floor_tick;
    logic [GAIN_W-1:0] target;

    tx_ramp_start u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready_i  (ready),
        .trig_pin (trig_pin),
        .cmd_wr   (cmd_wr),
        .cmd_code (cmd_code),
        .start_o  (start)
    );

    tx_ramp_ctrl #(
        .SYM_CYC   (SYM_CYC),
        .LEAD_UNIT (LEAD_UNIT),
        .STEP_CYC  (STEP_CYC),
        .GAIN_W    (GAIN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pll_locked (pll_locked),
        .start_i    (start),
        .lead_sel   (lead_sel),
        .gain_cfg   (gain_cfg),
        .tx_done    (tx_done),
        .floor_tick (floor_tick),
        .ready_o    (ready),
        .up_en      (up_en),
        .dn_en      (dn_en),
        .target_q   (target),
        .pa_en      (pa_en),
        .data_start (data_start),
        .busy_tx    (busy_tx),
        .ramp_done  (ramp_done)
    );

    tx_ramp_gain #(
        .GAIN_W   (GAIN_W),
        .STEP_CYC (STEP_CYC)
    ) u_gain (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_en      (up_en),
        .dn_en      (dn_en),
        .target     (target),
        .gain       (pa_gain),
        .floor_tick (floor_tick)
    );

    p_off_means_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_en |-> pa_gain == '0);

    p_ramp_by_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |-> pa_gain == target);
endmodule

// File: tb/test_tx_ramp_seq.sv
// Sweeps every gain and lead setting, rotating the start source, and checks
// every output in every cycle against arithmetic expectations.
module test_tx_ramp_seq;
    localparam int SYM  = 32;
    localparam int LU   = 4;
    localparam int STEP = 2;
    localparam int GW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pll_locked = 1'b0;
    logic          trig_pin = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [4:0]    cmd_code = 5'h00;
    logic [1:0]    lead_sel = 2'd0;
    logic [GW-1:0] gain_cfg = '0;
    logic          tx_done = 1'b0;
    logic          pa_en;
    logic [GW-1:0] pa_gain;
    logic          data_start;
    logic          busy_tx;
    logic          ramp_done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 0;

    tx_ramp_seq #(.SYM_CYC(SYM), .LEAD_UNIT(LU), .STEP_CYC(STEP), .GAIN_W(GW))
    i_tx_ramp_seq (
        .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .trig_pin(trig_pin),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code), .lead_sel(lead_sel),
        .gain_cfg(gain_cfg), .tx_done(tx_done), .pa_en(pa_en), .pa_gain(pa_gain),
        .data_start(data_start), .busy_tx(busy_tx), .ramp_done(ramp_done)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    // Idle output check: all quiet.
    task automatic chk_idle(input string req);
        chk(req, int'(busy_tx), 0);
        chk(req, int'(pa_en), 0);
        chk(req, int'(pa_gain), 0);
        chk(req, int'(data_start), 0);
    endtask

    // One full transmission. mode 0: pin, 1: command, 2: both (R8).
    task automatic run_one(input int g, input int ls, input int mode);
        int lead, on_at, eg;
        lead = (ls + 1) * LU;
        if (g * STEP > lead) lead = g * STEP;
        if (lead > SYM) lead = SYM;
        on_at = SYM - lead;
        @(negedge clk);
        gain_cfg = GW'(g);
        lead_sel = 2'(ls);
        cmd_code = 5'h02;
        if (mode != 1) trig_pin = 1'b1;
        if (mode != 0) cmd_wr = 1'b1;
        for (int n = 0; n <= 35; n++) begin
            @(negedge clk);
            cmd_wr  = (n == 5);               // R2: start while busy
            tx_done = (n == 10) || (n == 35); // R7: early done ignored
            eg = (n >= on_at) ? (n - on_at) / STEP : 0;
            if (eg > g) eg = g;
            chk("R1 busy", int'(busy_tx), 1);
            chk("R4 pa_en", int'(pa_en), (n >= on_at) ? 1 : 0);
            chk("R5 gain", int'(pa_gain), eg);
            chk(mode == 2 ? "R8 data_start" : "R3 data_start", int'(data_start), (n == SYM) ? 1 : 0);
            chk("R7 done", int'(ramp_done), 0);
        end
        for (int m = 0; m <= 2 * g + 3; m++) begin
            @(negedge clk);
            tx_done = 1'b0;
            if (m <= 2 * g + 1) begin
                eg = (m / STEP > g) ? 0 : g - m / STEP;
                chk("R6 gain down", int'(pa_gain), eg);
                chk("R6 pa_en", int'(pa_en), 1);
                chk("R7 busy", int'(busy_tx), 1);
                chk("R7 done", int'(ramp_done), 0);
            end else begin
                chk("R6 pa off", int'(pa_en), 0);
                chk("R7 busy off", int'(busy_tx), 0);
                chk("R7 done pulse", int'(ramp_done), (m == 2 * g + 2) ? 1 : 0);
            end
        end
        trig_pin = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(mode == 2 ? "R8 single run" : "R7 idle", int'(busy_tx), 0);
        end
    endtask

    initial begin
        trig_pin = 1'b1;   // held high across reset (R1)
        repeat (4) @(negedge clk);
        chk_idle("R9 reset");
        chk("R9 reset done", int'(ramp_done), 0);
        rst_n = 1'b1;
        pll_locked = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 held pin no start", int'(busy_tx), 0);
        trig_pin = 1'b0;
        pll_locked = 1'b0;
        @(negedge clk);
        // R2: requests while unlocked are ignored
        trig_pin = 1'b1;
        cmd_wr = 1'b1;
        cmd_code = 5'h02;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R2 unlocked");
        trig_pin = 1'b0;
        pll_locked = 1'b1;
        // R2: wrong command code ignored; R7: tx_done in idle ignored
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_code = 5'h03;
        tx_done = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        tx_done = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R2 bad code");
        chk("R7 idle done", int'(ramp_done), 0);
        for (int g = 0; g < (1 << GW); g++)
            for (int ls = 0; ls < 4; ls++)
                run_one(g, ls, (g + ls) % 3);
        finish_run();
    end
endmodule